// File: doc/BRIEF.md
# Digital PLL Phase Error Path

This block produces the phase error word that drives the loop filter of a digital phase-locked loop. It times the gap between a rising edge on the reference pulse input and a rising edge on the divider feedback input, counting ticks of the sampling clock. The measured gap is signed by which edge came first, and it saturates at a set bound. Both inputs are assumed to be already synchronous to the sampling clock.

The block then adds two static trims to the measured gap. The first is a signed 7-bit offset word whose step size depends on the selected reference type. The second is an unsigned 3-bit fine skew. The loop drives the average of this sum to zero, so any non-zero trim becomes a static phase skew between the reference and the loop output.

Before the sum leaves the block, a slope limiter bounds how far the output may move from one comparison to the next. A reference transient therefore cannot move the output phase faster than a set rate. Each time a new word is produced, a strobe is raised for one clock. All arithmetic runs in fine units, and one fine unit is one skew step.

Top module: `phase_err_path`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, `err_vld_o` is 0 and `err_o` is 0.
- R2: If the reference edge comes k sampling ticks before the feedback edge, the detector result is +k. If the feedback edge comes k ticks first, the result is -k. Each tick is worth TICK_UNITS (default 8) fine units in the sum.
- R3: If the reference and feedback rising edges are sampled in the same cycle, the detector result is 0.
- R4: The detector magnitude saturates at DET_LIM ticks (default 255), so a very late second edge yields ±DET_LIM.
- R5: The offset word `ofs_word_i` is read as two's complement and scaled by the reference type. For `ref_kind_i` = 2'b10 (1.544 MHz) each step is OFS_1544 fine units (default 11). For 2'b00 (8 kHz frame), 2'b01 (2.048 MHz) and 2'b11, each step is OFS_STD fine units (default 8).
- R6: The skew word `skew_i` is unsigned, and it adds skew × SKEW_UNITS fine units (default 1) on top of the offset.
- R7: Two successive output words differ by at most STEP_MAX fine units (default 64). If the new sum lies within that distance of the last output, the output equals the sum exactly. Otherwise the output moves exactly STEP_MAX toward the sum.
- R8: `err_vld_o` is high for exactly one cycle. It rises two cycles after the clock edge that samples the completing edge. `err_o` holds its value between strobes.
- R9: If the leading signal rises again before the other edge arrives, the measurement restarts from that newer edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Reference pulse, synchronous to clk |
| fb_i | input | 1 | Feedback pulse from the loop divider |
| ofs_word_i | input | 7 | Signed static phase offset word |
| skew_i | input | 3 | Unsigned fine skew trim |
| ref_kind_i | input | 2 | Reference type: 00 8 kHz, 01 2.048 MHz, 10 1.544 MHz, 11 treated as 01 |
| err_vld_o | output | 1 | One-cycle strobe marking a new error word |
| err_o | output | ERR_W (16) | Signed, slope-limited phase error in fine units |

## Verification
The completing edge is sampled at one clock edge, and three registers follow it: detector, adder and limiter. As a result, `err_vld_o` and the new `err_o` appear just after the second clock edge that follows it. For every measurement the bench samples one time unit after each rising edge. It expects the strobe to be low at the first two samples, high with the model value at the third, and low again at the fourth with the value held. The bench model tracks the last output and applies the step clamp itself. This keeps each expected value tied to the requirements even when a large jump is spread over several comparisons.

// File: rtl/phase_err_pkg.sv
// Shared types for the phase error path.
// Holds the reference-type encoding used to pick the offset step size.
package phase_err_pkg;

    typedef enum logic [1:0] {
        RK_FRM8K = 2'b00,
        RK_2048K = 2'b01,
        RK_1544K = 2'b10,
        RK_SPARE = 2'b11
    } ref_kind_e;

endpackage

// File: rtl/edge_phase_det.sv
// Edge phase detector.
// Counts sampling ticks from the first rising edge (reference or feedback)
// to the other one, and reports a signed result: positive when the reference
// leads. The magnitude saturates at DET_LIM. If the leading signal rises again
// while waiting, the count restarts. Assumes both inputs are synchronous to clk.
module edge_phase_det #(
    parameter int DET_LIM = 255,
    parameter int DET_W   = $clog2(DET_LIM + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_i,
    input  logic                    fb_i,
    output logic                    det_vld_o,
    output logic signed [DET_W-1:0] det_err_o
);

    localparam int CNT_W = DET_W - 1;
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(DET_LIM);

    typedef enum logic [1:0] {ST_IDLE, ST_REF_LEAD, ST_FB_LEAD} det_st_e;

    det_st_e          state;
    logic [CNT_W-1:0] cnt;
    logic             ref_q, fb_q;
    logic             ref_rise, fb_rise;

    // Rising-edge detection against the previous sample
    always_comb begin
        ref_rise = ref_i & ~ref_q;
        fb_rise  = fb_i & ~fb_q;
    end

    // Measurement state machine and saturating tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ref_q     <= 1'b0;
            fb_q      <= 1'b0;
            det_vld_o <= 1'b0;
            det_err_o <= '0;
        end else begin
            ref_q     <= ref_i;
            fb_q      <= fb_i;
            det_vld_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        det_vld_o <= 1'b1;
                        det_err_o <= '0;
                    end else if (ref_rise) begin
                        state <= ST_REF_LEAD;
                        cnt   <= CNT_W'(1);
                    end else if (fb_rise) begin
                        state <= ST_FB_LEAD;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_REF_LEAD: begin
                    if (fb_rise) begin
                        det_vld_o <= 1'b1;
                        det_err_o <= $signed({1'b0, cnt});
                        state     <= ST_IDLE;
                    end else if (ref_rise) begin
                        cnt <= CNT_W'(1);
                    end else if (cnt < LIM_C) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_FB_LEAD: begin
                    if (ref_rise) begin
                        det_vld_o <= 1'b1;
                        det_err_o <= -$signed({1'b0, cnt});
                        state     <= ST_IDLE;
                    end else if (fb_rise) begin
                        cnt <= CNT_W'(1);
                    end else if (cnt < LIM_C) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        det_vld_o |-> (det_err_o <= DET_W'(DET_LIM)) && (det_err_o >= -DET_W'(DET_LIM))); // R4

    AST_DET_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        det_vld_o |=> !det_vld_o); // R8

endmodule

// File: rtl/phase_offset_sum.sv
// Phase offset adder.
// Converts the detector result to fine units, then adds the signed offset word
// (its step size picked by the reference type) and the unsigned skew trim.
// The result is registered together with its strobe. Assumes the trim inputs
// are static while a measurement is in flight.
module phase_offset_sum
    import phase_err_pkg::*;
#(
    parameter int DET_W      = 9,
    parameter int ERR_W      = 16,
    parameter int TICK_UNITS = 8,
    parameter int OFS_STD    = 8,
    parameter int OFS_1544   = 11,
    parameter int SKEW_UNITS = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    det_vld_i,
    input  logic signed [DET_W-1:0] det_err_i,
    input  logic [6:0]              ofs_word_i,
    input  logic [2:0]              skew_i,
    input  ref_kind_e               ref_kind_i,
    output logic                    sum_vld_o,
    output logic signed [ERR_W-1:0] sum_err_o
);

    int ofs_mul;
    logic signed [31:0] det_f, ofs_f, skew_f, total;

    // Scale each contribution to fine units and add them up
    always_comb begin
        ofs_mul = (ref_kind_i == RK_1544K) ? OFS_1544 : OFS_STD;
        det_f   = 32'(det_err_i) * TICK_UNITS;
        ofs_f   = 32'($signed(ofs_word_i)) * ofs_mul;
        skew_f  = $signed({29'd0, skew_i}) * SKEW_UNITS;
        total   = det_f + ofs_f + skew_f;
    end

    // Register the corrected error together with its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_vld_o <= 1'b0;
            sum_err_o <= '0;
        end else begin
            sum_vld_o <= det_vld_i;
            if (det_vld_i) begin
                sum_err_o <= ERR_W'(total);
            end
        end
    end

endmodule

// File: rtl/slope_clamp.sv
// Phase slope limiter.
// Moves the output toward each new input word by at most STEP_MAX fine units.
// The output holds between strobes. The first reference point after reset is 0.
module slope_clamp #(
    parameter int ERR_W    = 16,
    parameter int STEP_MAX = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld_i,
    input  logic signed [ERR_W-1:0] in_err_i,
    output logic                    out_vld_o,
    output logic signed [ERR_W-1:0] out_err_o
);

    localparam int DW = ERR_W + 1;
    localparam logic signed [DW-1:0] STEP_P = DW'(STEP_MAX);

    logic signed [DW-1:0] diff, step;
    logic signed [ERR_W-1:0] nxt;

    // Clamp the change against the last output word
    always_comb begin
        diff = DW'(in_err_i) - DW'(out_err_o);
        if (diff > STEP_P) begin
            step = STEP_P;
        end else if (diff < -STEP_P) begin
            step = -STEP_P;
        end else begin
            step = diff;
        end
        nxt = ERR_W'(DW'(out_err_o) + step);
    end

    // Update the output only when a new word arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            out_err_o <= '0;
        end else begin
            out_vld_o <= in_vld_i;
            if (in_vld_i) begin
                out_err_o <= nxt;
            end
        end
    end

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> ((DW'(out_err_o) - DW'($past(out_err_o))) <= STEP_P)
                   && ((DW'(out_err_o) - DW'($past(out_err_o))) >= -STEP_P)); // R7

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> $stable(out_err_o)); // R8

endmodule

// File: rtl/phase_err_path.sv
// Phase error path top.
// Chain: edge detector -> offset/skew adder -> slope limiter. There are three
// register stages, so the output strobe follows the completing edge by two
// cycles after it is sampled. Assumes ref_i and fb_i are synchronous to clk.
module phase_err_path
    import phase_err_pkg::*;
#(
    parameter int DET_LIM    = 255,
    parameter int ERR_W      = 16,
    parameter int TICK_UNITS = 8,
    parameter int OFS_STD    = 8,
    parameter int OFS_1544   = 11,
    parameter int SKEW_UNITS = 1,
    parameter int STEP_MAX   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             fb_i,
    input  logic [6:0]       ofs_word_i,
    input  logic [2:0]       skew_i,
    input  logic [1:0]       ref_kind_i,
    output logic             err_vld_o,
    output logic [ERR_W-1:0] err_o
);

    localparam int DET_W = $clog2(DET_LIM + 1) + 1;

    logic                    det_vld;
    logic signed [DET_W-1:0] det_err;
    logic                    sum_vld;
    logic signed [ERR_W-1:0] sum_err;
    logic signed [ERR_W-1:0] lim_err;
    ref_kind_e               kind;

    // Map the raw select pins onto the reference-type encoding
    always_comb kind = ref_kind_e'(ref_kind_i);

    edge_phase_det #(.DET_LIM(DET_LIM), .DET_W(DET_W)) u_det (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i),
        .det_vld_o(det_vld), .det_err_o(det_err)
    );

    phase_offset_sum #(
        .DET_W(DET_W), .ERR_W(ERR_W), .TICK_UNITS(TICK_UNITS),
        .OFS_STD(OFS_STD), .OFS_1544(OFS_1544), .SKEW_UNITS(SKEW_UNITS)
    ) u_sum (
        .clk(clk), .rst_n(rst_n), .det_vld_i(det_vld), .det_err_i(det_err),
        .ofs_word_i(ofs_word_i), .skew_i(skew_i), .ref_kind_i(kind),
        .sum_vld_o(sum_vld), .sum_err_o(sum_err)
    );

    slope_clamp #(.ERR_W(ERR_W), .STEP_MAX(STEP_MAX)) u_clamp (
        .clk(clk), .rst_n(rst_n), .in_vld_i(sum_vld), .in_err_i(sum_err),
        .out_vld_o(err_vld_o), .out_err_o(lim_err)
    );

    // Drive the output word from the limiter
    always_comb err_o = lim_err;

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld_o == $past(det_vld, 2)); // R8

endmodule

// File: tb/sim_phase_err_path.sv
module sim_phase_err_path;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_i = 1'b0;
    logic        fb_i = 1'b0;
    logic [6:0]  ofs_word_i = '0;
    logic [2:0]  skew_i = '0;
    logic [1:0]  ref_kind_i = 2'b01;
    logic        err_vld_o;
    logic [15:0] err_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int model_prev = 0;

    localparam int LIM = 255;
    localparam int STEP = 64;

    always #5 clk = ~clk;

    phase_err_path u0 (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i),
        .ofs_word_i(ofs_word_i), .skew_i(skew_i), .ref_kind_i(ref_kind_i),
        .err_vld_o(err_vld_o), .err_o(err_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected fine-unit sum from the requirements, then the step clamp
    function automatic int model_out(input int det);
        int mul, ofs, sum, d;
        mul = (ref_kind_i == 2'b10) ? 11 : 8;
        ofs = int'($signed(ofs_word_i));
        sum = det * 8 + ofs * mul + int'(skew_i);
        d = sum - model_prev;
        if (d > STEP) d = STEP;
        if (d < -STEP) d = -STEP;
        return model_prev + d;
    endfunction

    // One comparison: ref pulses at r1 (and r2 if >= 0), feedback pulse at f
    task automatic run_meas(input int r1, input int r2, input int f, input string req);
        int m, det, start, exp;
        m = (r1 > f) ? r1 : f;
        if (r2 > m) m = r2;
        if (r1 == f) begin
            det = 0;
        end else if (r1 < f) begin
            start = (r2 >= 0 && r2 < f) ? r2 : r1;
            det = f - start;
            if (det > LIM) det = LIM;
        end else begin
            det = r1 - f;
            if (det > LIM) det = LIM;
            det = -det;
        end
        exp = model_out(det);
        for (int c = 0; c <= m; c++) begin
            @(posedge clk); #1;
            ref_i = (c == r1) || (c == r2);
            fb_i  = (c == f);
        end
        @(posedge clk); #1;
        ref_i = 1'b0; fb_i = 1'b0;
        check("R8", int'(err_vld_o), 0, "strobe early (1st)");
        @(posedge clk); #1;
        check("R8", int'(err_vld_o), 0, "strobe early (2nd)");
        @(posedge clk); #1;
        check("R8", int'(err_vld_o), 1, "strobe due");
        check(req, int'($signed(err_o)), exp, "error word");
        @(posedge clk); #1;
        check("R8", int'(err_vld_o), 0, "strobe one cycle");
        check("R8", int'($signed(err_o)), exp, "word held");
        model_prev = exp;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(err_vld_o), 0, "strobe in reset");
        check("R1", int'(err_o), 0, "word in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", int'(err_vld_o), 0, "strobe after reset");
        check("R1", int'(err_o), 0, "word after reset");
    endtask

    task automatic t_lead_lag();
        ofs_word_i = 7'd0; skew_i = 3'd0; ref_kind_i = 2'b01;
        run_meas(0, -1, 3, "R2");   // reference leads by 3 -> 24
        run_meas(5, -1, 0, "R2");   // feedback leads by 5 -> -40, step exactly 64
        run_meas(2, -1, 2, "R3");   // same-cycle edges -> 0
    endtask

    task automatic t_offsets();
        ofs_word_i = 7'd5; ref_kind_i = 2'b00;
        run_meas(1, -1, 1, "R5");   // 5*8 = 40
        ofs_word_i = 7'h7C; ref_kind_i = 2'b10;
        run_meas(1, -1, 1, "R5");   // -4*11 = -44
        ofs_word_i = 7'h7D; ref_kind_i = 2'b11;
        run_meas(1, -1, 1, "R5");   // -3*8 = -24
        ofs_word_i = 7'd0; skew_i = 3'd7; ref_kind_i = 2'b01;
        run_meas(1, -1, 1, "R6");   // skew 7 -> 7
        ofs_word_i = 7'd2; skew_i = 3'd3; ref_kind_i = 2'b10;
        run_meas(0, -1, 1, "R6");   // 8 + 22 + 3 = 33
        skew_i = 3'd0; ofs_word_i = 7'd0; ref_kind_i = 2'b01;
    endtask

    task automatic t_saturate();
        run_meas(0, -1, 300, "R4"); // late feedback -> saturated, step-clamped
        for (int i = 0; i < 32; i++) run_meas(0, -1, 300, "R7");
        check("R4", model_prev, LIM * 8, "settled saturated word");
        run_meas(300, -1, 0, "R7"); // large reverse jump clamped to -64
    endtask

    task automatic t_restart();
        for (int i = 0; i < 70; i++) run_meas(0, -1, 3, "R7");
        run_meas(0, 5, 8, "R9");    // second ref edge restarts: lead 3 -> 24
        check("R9", model_prev, 24, "restart value");
        run_meas(0, -1, 0, "R3");
    endtask

    initial begin
        t_reset();
        t_lead_lag();
        t_offsets();
        t_saturate();
        t_restart();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule